// File: doc/BRIEF.md
# ATA Programmed-I/O Register Access Engine

This block is the host side of single register accesses to an ATA device over the 16-bit parallel bus. A one-cycle request carries the register block select (command block or control block), a 3-bit register address, the direction and the write data. The engine then runs one bus cycle: chip select and address first, then the read or write strobe, a short hold, and a recovery gap. A read returns its data with a one-cycle done pulse. A write also ends with a done pulse.

Setup, minimum strobe width, recovery and ready-timeout counts are inputs, so one instance covers every PIO timing mode. The device can stretch the strobe by pulling its ready line low. That line passes through a two-flop synchronizer. If the device holds ready low for too long, the engine releases the strobe and reports an error with the done pulse. The data bus is split into out, output-enable and in, and the pad logic joins them.

Top module: `ata_pio_engine`

## Requirements
- R1: When `req_ctl_i`=0, only `cs_cmd_no` goes low for the access. When `req_ctl_i`=1, only `cs_ctl_no` goes low. The two are never low together.
- R2: `da_o` equals the requested address while the strobe is low, and it stays stable for the whole strobe.
- R3: The chip select is low for max(`cfg_setup_i`,1) cycles before the strobe falls.
- R4: On a read, `dior_no` pulses low and `dd_oe_o` stays low. `rdata_o` takes the value `dd_i` held in the last cycle of the strobe, which is when the strobe deasserts. `done_o` is high for exactly one cycle.
- R5: On a write, `diow_no` pulses low. `dd_oe_o` is high with `dd_o`=write data through the strobe and the first cycle after it. `dd_oe_o` is low in the cycle after that.
- R6: With `iordy_i` high, the strobe is low for exactly max(`cfg_active_i`,1) cycles.
- R7: A low `iordy_i` holds the strobe low past its minimum. If `iordy_i` rises during the D+1-th low cycle, the width is max(`cfg_active_i`,1, D+3). This includes the two synchronizer cycles.
- R8: If ready stays low, the strobe is released after max(`cfg_active_i`,1)+`cfg_timeout_i` cycles. `err_o` is then asserted together with `done_o`, and a read leaves `rdata_o` unchanged.
- R9: The chip select and address stay asserted in the first cycle after the strobe deasserts.
- R10: After the done cycle, `busy_o` stays high for exactly `cfg_recov_i` cycles. During that time both chip selects are high.
- R11: A request that arrives while `busy_o` is high is ignored.
- R12: After reset, both chip selects and both strobes are high, and `dd_oe_o`, `busy_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Start an access (taken when idle) |
| req_ctl_i | input | 1 | 0: command block, 1: control block |
| req_addr_i | input | 3 | Register address |
| req_wr_i | input | 1 | 1: write, 0: read |
| req_wdata_i | input | 16 | Write data |
| cfg_setup_i | input | CNT_W | Setup cycles before the strobe |
| cfg_active_i | input | CNT_W | Minimum strobe width in cycles |
| cfg_recov_i | input | CNT_W | Recovery cycles after an access |
| cfg_timeout_i | input | TO_W | Maximum ready-low stretch in cycles |
| busy_o | output | 1 | Access in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Ready timeout, valid with done_o |
| rdata_o | output | 16 | Last captured read data |
| cs_cmd_no | output | 1 | Command block chip select, active low |
| cs_ctl_no | output | 1 | Control block chip select, active low |
| da_o | output | 3 | Device address |
| dior_no | output | 1 | Read strobe, active low |
| diow_no | output | 1 | Write strobe, active low |
| dd_o | output | 16 | Data bus out |
| dd_oe_o | output | 1 | Data bus output enable |
| dd_i | input | 16 | Data bus in |
| iordy_i | input | 1 | Device ready, asynchronous |

## Verification
The bench builds the engine with CNT_W=4 and TO_W=5. With these values the largest setup, strobe and recovery counts (15) and a full timeout window are reached in a few dozen cycles. The bench runs zero counts to prove the one-cycle floor, and mixes normal, ready-stretched and timed-out accesses in both directions. Read data changes every strobe cycle, which shows that the capture happens at the deasserting edge rather than earlier in the pulse.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int unsigned DW = 16;
  localparam int unsigned AW = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACTIVE, ST_HOLD, ST_RECOV
  } pio_state_e;

  typedef struct packed {
    logic          ctl;
    logic          wr;
    logic [AW-1:0] addr;
    logic [DW-1:0] data;
  } pio_req_t;
endpackage

// File: rtl/ata_pio_sync.sv
module ata_pio_sync #(
  parameter int unsigned STAGES  = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] sh_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= RST_VAL;
        else         sh_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q <= {STAGES{RST_VAL}};
        else         sh_q <= {sh_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ata_pio_cnt.sv
// Phase timer: loaded on phase entry, phase ends when it reaches 1 (0 and 1 both mean one cycle)
module ata_pio_cnt #(
  parameter int unsigned W = 6
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] val_i,
  output logic         done_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (load_i)            cnt_q <= val_i;
    else if (cnt_q > W'(1))     cnt_q <= cnt_q - W'(1);
  end

  assign done_o = (cnt_q <= W'(1));
endmodule

// File: rtl/ata_pio_wdog.sv
module ata_pio_wdog #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         inc_i,
  input  logic [W-1:0] limit_i,
  output logic         expired_o
);
  logic [W-1:0] cnt_q;

  assign expired_o = inc_i && (cnt_q == limit_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (clr_i)               cnt_q <= '0;
    else if (inc_i && !expired_o) cnt_q <= cnt_q + W'(1);
  end
endmodule

// File: rtl/ata_pio_engine.sv
module ata_pio_engine
  import ata_pio_pkg::*;
#(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned TO_W  = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             req_i,
  input  logic             req_ctl_i,
  input  logic [AW-1:0]    req_addr_i,
  input  logic             req_wr_i,
  input  logic [DW-1:0]    req_wdata_i,
  input  logic [CNT_W-1:0] cfg_setup_i,
  input  logic [CNT_W-1:0] cfg_active_i,
  input  logic [CNT_W-1:0] cfg_recov_i,
  input  logic [TO_W-1:0]  cfg_timeout_i,
  output logic             busy_o,
  output logic             done_o,
  output logic             err_o,
  output logic [DW-1:0]    rdata_o,
  output logic             cs_cmd_no,
  output logic             cs_ctl_no,
  output logic [AW-1:0]    da_o,
  output logic             dior_no,
  output logic             diow_no,
  output logic [DW-1:0]    dd_o,
  output logic             dd_oe_o,
  input  logic [DW-1:0]    dd_i,
  input  logic             iordy_i
);
  pio_state_e       state_q, state_d;
  pio_req_t         req_q;
  logic [DW-1:0]    rdata_q;
  logic             err_q;
  logic             rdy_s, phase_done, expired;
  logic             cnt_load;
  logic [CNT_W-1:0] cnt_val;
  logic             stretch, strobe_end, cs_act;

  ata_pio_sync #(.STAGES(2), .RST_VAL(1'b1)) u_rdy_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(iordy_i), .q_o(rdy_s)
  );

  ata_pio_cnt #(.W(CNT_W)) u_phase (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(cnt_load), .val_i(cnt_val),
    .done_o(phase_done)
  );

  assign stretch = (state_q == ST_ACTIVE) && phase_done && !rdy_s;

  ata_pio_wdog #(.W(TO_W)) u_wdog (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(state_q != ST_ACTIVE),
    .inc_i(stretch), .limit_i(cfg_timeout_i), .expired_o(expired)
  );

  assign strobe_end = (state_q == ST_ACTIVE) && phase_done && (rdy_s || expired);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE:   if (req_i) state_d = ST_SETUP;
      ST_SETUP:  if (phase_done) state_d = ST_ACTIVE;
      ST_ACTIVE: if (strobe_end) state_d = ST_HOLD;
      ST_HOLD:   state_d = (cfg_recov_i == '0) ? ST_IDLE : ST_RECOV;
      ST_RECOV:  if (phase_done) state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  // reload the phase timer on every state change
  assign cnt_load = (state_d != state_q);
  always_comb begin
    unique case (state_d)
      ST_SETUP:  cnt_val = cfg_setup_i;
      ST_ACTIVE: cnt_val = cfg_active_i;
      ST_RECOV:  cnt_val = cfg_recov_i;
      default:   cnt_val = '0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      req_q   <= '0;
      rdata_q <= '0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_IDLE && req_i) begin
        req_q <= '{ctl: req_ctl_i, wr: req_wr_i, addr: req_addr_i, data: req_wdata_i};
        err_q <= 1'b0;
      end
      if (strobe_end) begin
        err_q <= expired;
        // capture on the deasserting edge of the read strobe
        if (!req_q.wr && !expired) rdata_q <= dd_i;
      end
    end
  end

  assign cs_act    = (state_q == ST_SETUP) || (state_q == ST_ACTIVE) || (state_q == ST_HOLD);
  assign cs_cmd_no = !(cs_act && !req_q.ctl);
  assign cs_ctl_no = !(cs_act &&  req_q.ctl);
  assign da_o      = req_q.addr;
  assign dior_no   = !(state_q == ST_ACTIVE && !req_q.wr);
  assign diow_no   = !(state_q == ST_ACTIVE &&  req_q.wr);
  assign dd_o      = req_q.data;
  assign dd_oe_o   = cs_act && req_q.wr;
  assign busy_o    = (state_q != ST_IDLE);
  assign done_o    = (state_q == ST_HOLD);
  assign err_o     = (state_q == ST_HOLD) && err_q;
  assign rdata_o   = rdata_q;
endmodule

// File: rtl/ata_pio_chk.sv
module ata_pio_chk
  import ata_pio_pkg::*;
(
  input logic          clk_i,
  input logic          rst_ni,
  input logic          cs_cmd_no,
  input logic          cs_ctl_no,
  input logic [AW-1:0] da_o,
  input logic          dior_no,
  input logic          diow_no,
  input logic          dd_oe_o,
  input logic          busy_o,
  input logic          done_o,
  input logic          err_o
);
  logic stb_low, cs_low;
  assign stb_low = !dior_no || !diow_no;
  assign cs_low  = !cs_cmd_no || !cs_ctl_no;

  a_r1_cs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!cs_cmd_no && !cs_ctl_no));
  a_r4_one_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!dior_no && !diow_no));
  a_r3_strobe_in_cs: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_low |-> cs_low);
  a_r2_addr_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stb_low |=> ($stable(da_o) && $stable(cs_cmd_no) && $stable(cs_ctl_no)));
  a_r9_cs_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(dior_no) || $rose(diow_no)) |-> cs_low);
  a_r5_bus_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(diow_no) |=> !dd_oe_o);
  a_r4_no_drive_on_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !dior_no |-> !dd_oe_o);
  a_r4_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);
  a_r8_err_with_done: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  a_r12_idle_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!cs_low && !stb_low && !dd_oe_o));
endmodule

bind ata_pio_engine ata_pio_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .cs_cmd_no(cs_cmd_no), .cs_ctl_no(cs_ctl_no),
  .da_o(da_o), .dior_no(dior_no), .diow_no(diow_no), .dd_oe_o(dd_oe_o),
  .busy_o(busy_o), .done_o(done_o), .err_o(err_o)
);

// File: tb/ata_pio_engine_tb.sv
module ata_pio_engine_tb;
  localparam int CNT_W = 4;
  localparam int TO_W  = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, req_ctl = 1'b0, req_wr = 1'b0;
  logic [2:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [CNT_W-1:0] cfg_setup = '0, cfg_active = '0, cfg_recov = '0;
  logic [TO_W-1:0] cfg_timeout = '1;
  logic busy, done, err, cs_cmd_n, cs_ctl_n, dior_n, diow_n, dd_oe;
  logic [15:0] rdata, dd_out;
  logic [15:0] dd_in = '0;
  logic [2:0] da;
  logic iordy = 1'b1;

  always #2 clk = ~clk;

  ata_pio_engine #(.CNT_W(CNT_W), .TO_W(TO_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .req_ctl_i(req_ctl),
    .req_addr_i(req_addr), .req_wr_i(req_wr), .req_wdata_i(req_wdata),
    .cfg_setup_i(cfg_setup), .cfg_active_i(cfg_active), .cfg_recov_i(cfg_recov),
    .cfg_timeout_i(cfg_timeout), .busy_o(busy), .done_o(done), .err_o(err),
    .rdata_o(rdata), .cs_cmd_no(cs_cmd_n), .cs_ctl_no(cs_ctl_n), .da_o(da),
    .dior_no(dior_n), .diow_no(diow_n), .dd_o(dd_out), .dd_oe_o(dd_oe),
    .dd_i(dd_in), .iordy_i(iordy)
  );

  typedef struct {
    bit wr; bit ctl; logic [2:0] addr; logic [15:0] wd;
    int setup; int width; bit err; int recov;
  } item_t;

  item_t exp_q[$];
  int total = 0, bad = 0, pushed = 0, dones = 0;

  task automatic check(input bit ok, input string req_tag, input string what,
                       input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req_tag, what, act, expv);
    end
  endtask

  function automatic int max3(input int a, input int b, input int c);
    int m = a;
    if (b > m) m = b;
    if (c > m) m = c;
    return m;
  endfunction

  // mode: 0 ready high, 1 ready raised D cycles into the strobe, 2 ready never
  task automatic do_access(input bit wr, input bit ctl, input logic [2:0] addr,
                           input logic [15:0] wd, input int s, input int a,
                           input int r, input int t, input int mode, input int d,
                           input bit poke);
    item_t it;
    it.wr = wr; it.ctl = ctl; it.addr = addr; it.wd = wd;
    it.setup = max3(s, 1, 1);
    it.recov = r;
    it.err = (mode == 2);
    if (mode == 0)      it.width = max3(a, 1, 1);
    else if (mode == 1) it.width = max3(a, 1, d + 3);
    else                it.width = max3(a, 1, 1) + t;
    exp_q.push_back(it);
    pushed++;
    @(negedge clk);
    cfg_setup = CNT_W'(s); cfg_active = CNT_W'(a); cfg_recov = CNT_W'(r);
    cfg_timeout = TO_W'(t);
    iordy = (mode == 0);
    req = 1'b1; req_wr = wr; req_ctl = ctl; req_addr = addr; req_wdata = wd;
    @(negedge clk);
    req = 1'b0;
    if (poke) begin // R11: request while busy must be ignored
      req = 1'b1; req_addr = ~addr; req_wr = ~wr; req_ctl = ~ctl;
      @(negedge clk);
      req = 1'b0;
    end
    if (mode == 1) begin
      while (dior_n && diow_n) @(negedge clk);
      repeat (d) @(negedge clk);
      iordy = 1'b1;
    end
    while (busy) @(negedge clk);
    iordy = 1'b1;
    @(negedge clk);
  endtask

  // monitor / scoreboard
  bit prev_stb = 0, rel_chk = 0, rec_act = 0;
  int stb_len = 0, setup_ctr = 0, rec_ctr = 0, rec_exp = 0, rd_ctr = 0;
  logic [15:0] last_drive = '0, held = '0;

  always @(negedge clk) begin
    if (rst_n) begin
      automatic bit stb = !dior_n || !diow_n;
      automatic bit csl = !cs_cmd_n || !cs_ctl_n;
      automatic item_t cur;
      if (exp_q.size() > 0) cur = exp_q[0];
      if (stb) begin
        if (!prev_stb) begin
          check(setup_ctr == cur.setup, "R3", "setup cycles", setup_ctr, cur.setup);
          check(cs_cmd_n == cur.ctl && cs_ctl_n == !cur.ctl, "R1", "chip select",
                {cs_ctl_n, cs_cmd_n}, {!cur.ctl, cur.ctl});
          check(da == cur.addr, "R2", "address", da, cur.addr);
          check(dior_n == cur.wr && diow_n == !cur.wr, "R4", "strobe kind",
                {diow_n, dior_n}, {!cur.wr, cur.wr});
          stb_len = 1;
        end else stb_len++;
        if (cur.wr) check(dd_oe && dd_out == cur.wd, "R5", "write data", dd_out, cur.wd);
        else        check(!dd_oe, "R4", "no drive on read", dd_oe, 0);
      end else if (prev_stb) begin
        check(stb_len == cur.width, cur.err ? "R8" : "R6_R7", "strobe width",
              stb_len, cur.width);
        check(csl && da == cur.addr, "R9", "hold after strobe", {csl, da}, {1'b1, cur.addr});
        if (cur.wr) check(dd_oe && dd_out == cur.wd, "R5", "data held", dd_out, cur.wd);
        rel_chk = cur.wr;
      end else if (rel_chk) begin
        check(!dd_oe, "R5", "bus release", dd_oe, 0);
        rel_chk = 0;
      end
      if (rec_act) begin
        if (busy) begin
          rec_ctr++;
          check(!csl, "R10", "cs idle in recovery", csl, 0);
        end else begin
          check(rec_ctr == rec_exp, "R10", "recovery cycles", rec_ctr, rec_exp);
          rec_act = 0;
        end
      end
      if (done) begin
        dones++;
        if (exp_q.size() == 0) check(0, "R11", "unexpected done", 1, 0);
        else begin
          cur = exp_q.pop_front();
          check(err == cur.err, "R8", "error flag", err, cur.err);
          if (!cur.wr) begin
            if (!cur.err) held = last_drive;
            check(rdata == held, cur.err ? "R8" : "R4", "read data", rdata, held);
          end
          rec_act = 1; rec_ctr = 0; rec_exp = cur.recov;
        end
      end
      setup_ctr = (csl && !stb) ? setup_ctr + 1 : 0;
      prev_stb = stb;
      // device side: change read data every strobe cycle
      if (!dior_n) begin
        rd_ctr++;
        dd_in = 16'h5A00 ^ 16'(rd_ctr * 16'h0137);
        last_drive = dd_in;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    check(0, "WDOG", "watchdog expired", 0, 1);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(cs_cmd_n && cs_ctl_n && dior_n && diow_n && !dd_oe && !busy && !done,
          "R12", "reset state", {cs_cmd_n, cs_ctl_n, dior_n, diow_n, dd_oe, busy, done},
          7'b1111000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    do_access(0, 0, 3'd7, 16'h0000, 2, 3, 2, 31, 0, 0, 0);
    do_access(1, 1, 3'd6, 16'h1234, 1, 1, 0, 31, 0, 0, 0);
    do_access(1, 0, 3'd0, 16'hBEEF, 5, 4, 3, 31, 0, 0, 0);
    do_access(0, 1, 3'd2, 16'h0000, 0, 0, 1, 31, 0, 0, 0);
    do_access(0, 0, 3'd5, 16'h0000, 3, 2, 1, 31, 1, 6, 0);
    do_access(1, 0, 3'd3, 16'hA5C3, 1, 8, 0, 31, 1, 0, 0);
    do_access(0, 0, 3'd1, 16'h0000, 2, 3, 2, 6, 2, 0, 0);
    do_access(1, 1, 3'd4, 16'h0F0F, 1, 2, 1, 4, 2, 0, 0);
    do_access(0, 1, 3'd6, 16'h0000, 2, 2, 2, 31, 0, 0, 1);
    do_access(0, 0, 3'd3, 16'h0000, 15, 15, 15, 31, 0, 0, 0);
    repeat (5) @(negedge clk);
    check(exp_q.size() == 0 && dones == pushed, "R11", "one done per accepted request",
          dones, pushed);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule